// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer

This block controls the low-power sleep state of a synchronous SRAM core. A sleep request arrives asynchronously and active high. The block brings it into the clock domain and steps through entry and exit phases with fixed, counted latencies. It produces the signals the rest of the core acts on:

- an input-gating signal that stops every other synchronous input from being sampled;
- a forced deselect toward the cycle controller;
- a high-impedance control for the data outputs;
- a low-current status flag.

The array keeps its contents while asleep. The block never touches the stored data.

The deselect and output disable are applied one cycle after the synchronized request rises. This blocks any new access while entry completes, and an access still pending at that point is dropped. Input gating and the status flag follow after `ENTER_CYC` cycles. Release takes `EXIT_CYC` cycles. A request that drops during entry returns the block to normal operation and issues no access. A request that returns during exit goes straight back to sleep, and the inputs stay gated throughout.

Top module: `sleep_gate`

## Requirements
- R1: While `rst_ni` is low, all four outputs are 0, whatever the request does.
- R2: The request passes through a two-flop synchronizer. Every output stays unchanged through the first two rising edges after the request changes.
- R3: `in_gate_o` rises `ENTER_CYC` (default 2) edges after the synchronized request rises. That is the fourth edge after the raw request rises.
- R4: `force_desel_o` and `dq_hiz_o` rise on the edge after the synchronized request rises, which is the third edge after the raw request. They stay high for as long as `in_gate_o` is high.
- R5: Once asleep, all outputs fall together `EXIT_CYC` (default 2) edges after the synchronized request falls. That is the fourth edge after the raw request falls.
- R6: If the synchronized request falls before entry completes, `in_gate_o` never rises. The deselect and output disable clear on the next edge.
- R7: If the synchronized request rises again during exit, the block returns to sleep. `in_gate_o` stays high without a gap.
- R8: `low_pwr_o` always equals `in_gate_o`, and `dq_hiz_o` always equals `force_desel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Asynchronous active-high sleep request |
| in_gate_o | output | 1 | High: synchronous inputs other than the request are ignored |
| force_desel_o | output | 1 | High: cycle controller must treat every cycle as deselected |
| dq_hiz_o | output | 1 | High: data output drivers held in high impedance |
| low_pwr_o | output | 1 | Low-current status flag |

## Verification
The hardest states to reach are the two interrupted transitions: a request that drops inside the single entry cycle, and a request that comes back inside the single exit cycle. From the pins, each needs the raw request to toggle on exactly the right edge, with the synchronizer delay counted in. The stimulus table produces a one-cycle request pulse, which becomes a one-cycle synchronized pulse that lands in the entry phase. It also produces a one-cycle low dip while asleep, which lands in the exit phase. At every edge the table checks that the gate neither asserts in the first case nor drops in the second.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_EXIT  = 2'd3
  } sleep_state_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_pkg::*;
#(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  output logic gate_o,
  output logic desel_o
);
  localparam int MAX_CYC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(ENTER_CYC - 2);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 2);

  sleep_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_AWAKE: if (req_s_i) state_d = ST_ENTER;
      ST_ENTER: begin
        if (!req_s_i)                 state_d = ST_AWAKE;  // abort, nothing issued
        else if (cnt_q == ENTER_LAST) state_d = ST_SLEEP;
        else                          cnt_d   = cnt_q + 1'b1;
      end
      ST_SLEEP: if (!req_s_i) state_d = ST_EXIT;
      ST_EXIT: begin
        if (req_s_i)                 state_d = ST_SLEEP;   // re-request, stay gated
        else if (cnt_q == EXIT_LAST) state_d = ST_AWAKE;
        else                         cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gate_o  = (state_q == ST_SLEEP) || (state_q == ST_EXIT);
  assign desel_o = (state_q != ST_AWAKE);

  assert_gate_implies_desel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> desel_o);
  assert_gate_after_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> ($past(req_s_i, 1) && $past(req_s_i, 2)));
  assert_abort_no_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER && !req_s_i) |=> (!gate_o && !desel_o));
  assert_reenter_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXIT && req_s_i) |=> gate_o);
  assert_release_together_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(desel_o) |-> !gate_o);
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_CYC - 2));
endmodule

// File: rtl/sleep_gate.sv
module sleep_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  output logic in_gate_o,
  output logic force_desel_o,
  output logic dq_hiz_o,
  output logic low_pwr_o
);
  logic req_s, gate, desel;

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (req_s)
  );

  sleep_seq #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_s_i(req_s),
    .gate_o (gate),
    .desel_o(desel)
  );

  assign in_gate_o     = gate;
  assign low_pwr_o     = gate;
  assign force_desel_o = desel;
  assign dq_hiz_o      = desel;

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !(in_gate_o || force_desel_o || dq_hiz_o || low_pwr_o));
  assert_flag_tracks_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_pwr_o == in_gate_o) && (dq_hiz_o == force_desel_o));
endmodule

// File: tb/sleep_gate_test.sv
module sleep_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic gate, desel, hiz, lowp;
  int   n_run = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  sleep_gate uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sleep_req_i  (req),
    .in_gate_o    (gate),
    .force_desel_o(desel),
    .dq_hiz_o     (hiz),
    .low_pwr_o    (lowp)
  );

  // {req driven before edge, expected desel after edge, expected gate after edge}
  localparam int NV = 28;
  localparam logic [2:0] VEC [NV] = '{
    3'b100, 3'b100, 3'b110, 3'b111, 3'b111,
    3'b011, 3'b011, 3'b011, 3'b000, 3'b000,
    3'b100, 3'b000, 3'b010, 3'b000, 3'b000,
    3'b100, 3'b100, 3'b110, 3'b111, 3'b011,
    3'b111, 3'b111, 3'b111, 3'b111, 3'b011,
    3'b011, 3'b011, 3'b000
  };

  task automatic check(input logic got, input logic exp, input string tag, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  function automatic string tag_of(input int i, input bit is_gate);
    if (i < 2)   return "R2";
    if (i < 5)   return is_gate ? "R3" : "R4";
    if (i < 10)  return "R5";
    if (i < 15)  return "R6";
    return "R7";
  endfunction

  initial begin
    #4000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, request toggling during reset
    req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gate, 1'b0, "R1", "in_gate in reset");
    check(desel, 1'b0, "R1", "desel in reset");
    check(hiz, 1'b0, "R1", "hiz in reset");
    check(lowp, 1'b0, "R1", "low_pwr in reset");
    req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      req = VEC[i][2];
      @(posedge clk);
      @(negedge clk);
      check(desel, VEC[i][1], tag_of(i, 1'b0), $sformatf("force_desel step %0d", i));
      check(gate, VEC[i][0], tag_of(i, 1'b1), $sformatf("in_gate step %0d", i));
      check(lowp, gate, "R8", $sformatf("low_pwr vs gate step %0d", i));
      check(hiz, desel, "R8", $sformatf("hiz vs desel step %0d", i));
    end

    // R1: reset asserted while asleep clears everything at once
    req = 1'b1;
    repeat (5) @(negedge clk);
    check(gate, 1'b1, "R3", "asleep before reset");
    #1 rst_n = 1'b0;
    #0.5;
    check(gate, 1'b0, "R1", "gate after async reset");
    check(desel, 1'b0, "R1", "desel after async reset");
    req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(desel, 1'b0, "R1", "idle after reset release");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule